// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block models a 24-bit-wide static memory whose interface has no strobe timing of its own. Three chip enables choose the device: two are active low and one is active high. An active-low write enable selects between read and write. An active-low output enable gates the read drivers. Three active-low byte enables gate each 8-bit lane on its own, for both reads and writes. The depth is a parameter, 256 words by default. The address port keeps the full 17-bit word address and the model uses only its low bits.

Reads are combinational from the array. High impedance on a lane is represented by its drive flag being low; the lane's data bits then read as zero. A write is open while the device is selected with the write enable low. On every clock edge of that window the model captures the address, data and byte enables. The write ends when the write enable rises or the device is deselected. The array takes the last captured values at the first clock edge on which the write condition is seen false. A standby output is high whenever the select decode is false.

Top module: `bytelane_sram`

## Requirements
- R1: The device is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1; `standby` is high for every other combination and low when selected.
- R2: While `standby` is high, `lane_drive` is 3'b000 and `rdata` is all zero, whatever the other inputs.
- R3: When selected with `wr_n`=1 and `rd_oe_n`=0, `lane_drive[k]` equals the inverse of `lane_en_n[k]`, and driven lanes show the stored word at the addressed location in the same cycle, without waiting for a clock.
- R4: When selected with `rd_oe_n`=1 and `wr_n`=1, no lane is driven and `standby` stays low.
- R5: A write is open while selected with `wr_n`=0. The stored value is the address, data and byte enables sampled at the last clock edge on which the write was open. That value is committed at the first clock edge on which the write condition is false.
- R6: `lane_en_n[0]` gates bits 7:0, `lane_en_n[1]` gates bits 15:8 and `lane_en_n[2]` gates bits 23:16 for both reads and writes. In a write, a lane whose enable is high keeps its old content.
- R7: A write with `lane_en_n`=3'b111 leaves the addressed word unchanged.
- R8: During an open write no lane is driven, and `rd_oe_n` has no effect on the stored result.
- R9: Deselecting the device while `wr_n` is low ends the write and commits it, just as a rise of `wr_n` does.
- R10: Only the low log2(DEPTH) bits of `addr` select a word; addresses that differ only above those bits reach the same word.
- R11: A write still open when reset is asserted is discarded; the addressed word keeps its old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for write capture and commit |
| rst_n | input | 1 | Active-low asynchronous reset of the write capture |
| addr | input | 17 | Word address |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b_n | input | 1 | Chip enable, active low |
| cs_c | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Write enable, active low |
| rd_oe_n | input | 1 | Output enable, active low |
| lane_en_n | input | 3 | Byte-lane enables, active low, bit k for bits 8k+7:8k |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data, zero on lanes not driven |
| lane_drive | output | 3 | Per-lane drive flag; low means the lane is at high impedance |
| standby | output | 1 | High when the select decode is false |

## Verification
The assertions assume that control and data inputs change only between clock edges and hold steady across each edge. They also assume the address is a known value whenever a write is captured. The bench drives every input on the falling edge and reads the combinational outputs a nanosecond later. Each write keeps `wr_n` low across at least one rising edge and ends on the next falling edge. Addresses used with a truncated upper part are chosen so that the low bits name words already written.

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 17,
  parameter int LANES  = 3,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     cs_a_n,
  input  logic                     cs_b_n,
  input  logic                     cs_c,
  input  logic                     wr_n,
  input  logic                     rd_oe_n,
  input  logic [LANES-1:0]         lane_en_n,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic [LANES-1:0]         lane_drive,
  output logic                     standby
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int IDX_W  = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              sel, wr_open, rd_open, commit;
  logic              pend;
  logic [IDX_W-1:0]  a_q;
  logic [DATA_W-1:0] d_q;
  logic [LANES-1:0]  be_q;

  wire unused_addr_hi = ^addr[ADDR_W-1:IDX_W];

  assign idx     = addr[IDX_W-1:0];
  assign sel     = ~cs_a_n & ~cs_b_n & cs_c;
  assign standby = ~sel;
  assign wr_open = sel & ~wr_n;
  assign rd_open = sel & wr_n & ~rd_oe_n;
  assign commit  = pend & ~wr_open;

  assign lane_drive = {LANES{rd_open}} & ~lane_en_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdata[l*LANE_W +: LANE_W] =
      lane_drive[l] ? mem[idx][l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
      be_q <= '1;
    end else begin
      pend <= wr_open;
      if (wr_open) begin
        a_q  <= idx;
        d_q  <= wdata;
        be_q <= lane_en_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (!be_q[l]) mem[a_q][l*LANE_W +: LANE_W] <= d_q[l*LANE_W +: LANE_W];
      end
    end
  end

  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (lane_drive == '0 && rdata == '0));

  // R8
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby && !wr_n) |-> lane_drive == '0);

  // R4
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_drive != '0) |-> (!rd_oe_n && !standby));

  // R5
  commit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend);

  // R7
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && be_q == '1) |=> mem[$past(a_q)] == $past(mem[a_q]));

endmodule

// File: tb/bytelane_sram_tb.sv
module bytelane_sram_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [16:0] addr = '0;
  logic        cs_a_n = 1, cs_b_n = 1, cs_c = 0, wr_n = 1, rd_oe_n = 1;
  logic [2:0]  lane_en_n = 3'b111;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic [2:0]  lane_drive;
  logic        standby;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bytelane_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .cs_c(cs_c), .wr_n(wr_n), .rd_oe_n(rd_oe_n), .lane_en_n(lane_en_n),
    .wdata(wdata), .rdata(rdata), .lane_drive(lane_drive), .standby(standby)
  );

  // {cs_a_n,cs_b_n,cs_c,wr_n,rd_oe_n,lane_en_n[2:0]} {standby,lane_drive} rdata
  localparam logic [35:0] VEC [11] = '{
    {8'b00110000, 4'b0111, 24'hA1B2C3},
    {8'b00110110, 4'b0001, 24'h0000C3},
    {8'b00110101, 4'b0010, 24'h00B200},
    {8'b00110011, 4'b0100, 24'hA10000},
    {8'b00110010, 4'b0101, 24'hA100C3},
    {8'b00110111, 4'b0000, 24'h000000},
    {8'b00111000, 4'b0000, 24'h000000},
    {8'b10110000, 4'b1000, 24'h000000},
    {8'b01110000, 4'b1000, 24'h000000},
    {8'b00010000, 4'b1000, 24'h000000},
    {8'b11000000, 4'b1000, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_read(input logic [16:0] a);
    @(negedge clk);
    cs_a_n = 0; cs_b_n = 0; cs_c = 1; wr_n = 1; rd_oe_n = 0;
    lane_en_n = 3'b000; addr = a;
    #1;
  endtask

  task automatic wr(input logic [16:0] a, input logic [23:0] d,
                    input logic [2:0] be, input bit by_deselect);
    @(negedge clk);
    cs_a_n = 0; cs_b_n = 0; cs_c = 1; wr_n = 0; rd_oe_n = 0;
    addr = a; wdata = d; lane_en_n = be;
    #1 chk("R8", {29'd0, lane_drive}, 32'd0);
    @(negedge clk);
    if (by_deselect) cs_c = 0; else wr_n = 1;
    wdata = ~d;
    @(negedge clk);
    cs_c = 1; wr_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1", {31'd0, standby}, 32'd1);
    chk("R2", {5'd0, lane_drive, rdata}, 32'd0);
    rst_n = 1;

    wr(17'd4, 24'hA1B2C3, 3'b000, 0);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      {cs_a_n, cs_b_n, cs_c, wr_n, rd_oe_n, lane_en_n} = VEC[i][35:28];
      addr = 17'd4;
      #1;
      chk("R1 R2 R3 R4 R6", {28'd0, standby, lane_drive}, {28'd0, VEC[i][27:24]});
      chk("R3 R6 rdata", {8'd0, rdata}, {8'd0, VEC[i][23:0]});
    end
    idle_read(17'd4);
    chk("R1 deselected write ignored", {8'd0, rdata}, 32'h00A1B2C3);

    wr(17'd4, 24'h112233, 3'b101, 0);
    idle_read(17'd4);
    chk("R6", {8'd0, rdata}, 32'h00A122C3);

    wr(17'd4, 24'hFFFFFF, 3'b111, 0);
    idle_read(17'd4);
    chk("R7", {8'd0, rdata}, 32'h00A122C3);

    wr(17'd9, 24'h5A5A5A, 3'b000, 1);
    idle_read(17'd9);
    chk("R9", {8'd0, rdata}, 32'h005A5A5A);

    // R5: last value sampled while open wins
    @(negedge clk);
    cs_a_n = 0; cs_b_n = 0; cs_c = 1; wr_n = 0; rd_oe_n = 1;
    addr = 17'd12; wdata = 24'h010203; lane_en_n = 3'b000;
    @(negedge clk);
    wdata = 24'h0A0B0C;
    @(negedge clk);
    wr_n = 1; wdata = 24'hEEEEEE;
    #1 chk("R5 not yet committed", {31'd0, standby}, 32'd0);
    @(negedge clk);
    idle_read(17'd12);
    chk("R5", {8'd0, rdata}, 32'h000A0B0C);

    // R10: upper address bits ignored
    idle_read(17'd12 + 17'd768);
    chk("R10", {8'd0, rdata}, 32'h000A0B0C);
    wr(17'd4 + 17'd256, 24'h778899, 3'b000, 0);
    idle_read(17'd4);
    chk("R10 alias write", {8'd0, rdata}, 32'h00778899);

    // R11: write interrupted by reset is discarded
    @(negedge clk);
    wr_n = 0; addr = 17'd9; wdata = 24'h123456; lane_en_n = 3'b000;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    wr_n = 1;
    @(negedge clk);
    rst_n = 1;
    idle_read(17'd9);
    chk("R11", {8'd0, rdata}, 32'h005A5A5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule